// File: doc/BRIEF.md
# CRC Accumulate Execution Unit

This processor functional unit executes a family of eight CRC-accumulate instructions. Each instruction folds 1, 2, 4 or 8 bytes of a message operand into a running 32-bit checksum. The checksum can use the IEEE CRC-32 polynomial or the Castagnoli CRC-32C polynomial, both in reflected, LSB-first form. The issue stage presents the instruction word, the running checksum (read from the register named by bits 20:16), the message (read from the register named by bits 25:21), a feature-enable bit and a 64-bit-mode flag, and pulses `start`.

The unit checks legality in the same cycle and reports a reserved-instruction exception at once. A legal instruction then consumes one message byte per clock, least-significant byte first. When it finishes, it returns the updated checksum sign-extended to 64 bits, along with a one-cycle `done` and a write-enable for the destination register. No initial or final inversion is applied, so software chains instructions and inverts at the ends itself.

Top module: `crc_accum_unit`

## Requirements
- R1: An instruction is legal only if bits 31:26 are 0x1F, bits 5:0 are 0x0F and bits 15:11 are all zero. Any other word raises the exception.
- R2: Bits 7:6 select the message length: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. If `start` is sampled at clock edge E, bytes are consumed on edges E+1 to E+N, and `done` is high for exactly the cycle after edge E+N.
- R3: Bits 10:8 select the polynomial: 0 = reflected 0xEDB88320 and 1 = reflected 0x82F63B78. A value of 2 or more raises the exception.
- R4: The exception is also raised when `featEn` is low, or when the length field is 3 while `mode64` is low.
- R5: `rsvdExc` is combinational and is high only in a start cycle that the unit accepts. After such a start, `done` is high in the cycle after edge E, with `wrEn` low.
- R6: The message is masked to the selected length, so message bits above it have no effect. Bytes are consumed starting from bits 7:0.
- R7: The checksum input is bits 31:0 of `crcIn`, with no inversion applied. Bits 63:32 of `crcIn` are ignored.
- R8: On `done`, `result` holds the 32-bit checksum with bit 31 copied into bits 63:32.
- R9: When the destination index (bits 20:16) is zero, the instruction runs with normal latency, but `wrEn` stays low on `done`.
- R10: A `start` that arrives while an instruction is still consuming bytes is ignored. It does not disturb the running result and produces no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Issue strobe for the instruction on `instr` |
| instr | input | 32 | Instruction word |
| crcIn | input | 64 | Running checksum operand (destination register value) |
| msgIn | input | 64 | Message operand |
| featEn | input | 1 | CRC instructions enabled |
| mode64 | input | 1 | 64-bit operations enabled |
| rsvdExc | output | 1 | Reserved-instruction exception, valid in the start cycle |
| done | output | 1 | One-cycle completion pulse |
| wrEn | output | 1 | Destination write enable, valid with `done` |
| result | output | 64 | Sign-extended updated checksum |

## Verification
The bench chains a doubleword step and a byte step over the ASCII string "123456789" and compares the result with the well-known check values of both polynomials. A unit that fed bytes in the wrong order, or that used the wrong polynomial, would miss these values. Every illegal encoding and mode combination is driven, because a decoder that let one through would write a result instead of trapping. Junk bits above the selected length expose a missing mask, and a zero destination index exposes a write-enable that ignores the discard case. A restart during a busy period catches a controller that reloads mid-run or issues a second `done`.

// File: rtl/crc_accum_pkg.sv
package crc_accum_pkg;
  localparam int XLEN    = 64;
  localparam int CRC_W   = 32;
  localparam int BYTE_W  = 8;
  localparam int MAX_BYTES = XLEN / BYTE_W;
  localparam int CNT_W   = $clog2(MAX_BYTES + 1);

  localparam logic [CRC_W-1:0] POLY_IEEE = 32'hEDB88320;
  localparam logic [CRC_W-1:0] POLY_CAST = 32'h82F63B78;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic load;
    logic step;
  } dpCtrl_t;
endpackage

// File: rtl/crc_accum_decode.sv
module crc_accum_decode
  import crc_accum_pkg::*;
(
  input  logic [31:0]      instr,
  input  logic             featEn,
  input  logic             mode64,
  output logic             bad,
  output logic [CNT_W-1:0] nBytes,
  output logic             castagSel,
  output logic             noWrite
);
  logic       opMatch;
  logic [1:0] sizeFld;
  logic [2:0] polyFld;

  assign sizeFld = instr[7:6];
  assign polyFld = instr[10:8];
  assign opMatch = (instr[31:26] == 6'h1F) && (instr[5:0] == 6'h0F) &&
                   (instr[15:11] == 5'd0);

  always_comb begin
    bad = !opMatch || (polyFld > 3'd1) || !featEn ||
          ((sizeFld == 2'd3) && !mode64);
    nBytes    = CNT_W'(1) << sizeFld;
    castagSel = polyFld[0];
    noWrite   = (instr[20:16] == 5'd0);
  end
endmodule

// File: rtl/crc_accum_ctrl.sv
module crc_accum_ctrl
  import crc_accum_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             bad,
  input  logic             noWrite,
  input  logic [CNT_W-1:0] nBytes,
  output dpCtrl_t          dpCtrl,
  output logic             busy,
  output logic             done,
  output logic             wrEn
);
  logic [CNT_W-1:0] remain;
  logic             discardQ;
  logic             accept;

  assign accept      = start && !busy;
  assign dpCtrl.load = accept && !bad;
  assign dpCtrl.step = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      remain   <= '0;
      discardQ <= 1'b0;
      done     <= 1'b0;
      wrEn     <= 1'b0;
    end else begin
      done <= 1'b0;
      wrEn <= 1'b0;
      if (accept) begin
        if (bad) begin
          done <= 1'b1;
        end else begin
          busy     <= 1'b1;
          remain   <= nBytes;
          discardQ <= noWrite;
        end
      end else if (busy) begin
        remain <= remain - CNT_W'(1);
        if (remain == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          wrEn <= !discardQ;
        end
      end
    end
  end
endmodule

// File: rtl/crc_accum_dp.sv
module crc_accum_dp
  import crc_accum_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  dpCtrl_t          dpCtrl,
  input  logic [XLEN-1:0]  crcIn,
  input  logic [XLEN-1:0]  msgIn,
  input  logic [CNT_W-1:0] nBytes,
  input  logic             castagSel,
  output logic [XLEN-1:0]  result
);
  logic [CRC_W-1:0] crcQ;
  logic [CRC_W-1:0] polyQ;
  logic [XLEN-1:0]  msgQ;
  logic [XLEN-1:0]  msgMasked;
  logic [CRC_W-1:0] crcNext;

  // Keep only the bytes the size field selects
  for (genvar g = 0; g < MAX_BYTES; g++) begin : gMask
    assign msgMasked[g*BYTE_W +: BYTE_W] =
      (g < int'(nBytes)) ? msgIn[g*BYTE_W +: BYTE_W] : '0;
  end

  always_comb begin
    logic [CRC_W-1:0] c;
    c = crcQ ^ {{(CRC_W-BYTE_W){1'b0}}, msgQ[BYTE_W-1:0]};
    for (int b = 0; b < BYTE_W; b++) begin
      c = c[0] ? ((c >> 1) ^ polyQ) : (c >> 1);
    end
    crcNext = c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crcQ  <= '0;
      polyQ <= '0;
      msgQ  <= '0;
    end else if (dpCtrl.load) begin
      crcQ  <= crcIn[CRC_W-1:0];
      polyQ <= castagSel ? POLY_CAST : POLY_IEEE;
      msgQ  <= msgMasked;
    end else if (dpCtrl.step) begin
      crcQ <= crcNext;
      msgQ <= msgQ >> BYTE_W;
    end
  end

  assign result = {{(XLEN-CRC_W){crcQ[CRC_W-1]}}, crcQ};
endmodule

// File: rtl/crc_accum_unit.sv
module crc_accum_unit
  import crc_accum_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] instr,
  input  logic [63:0] crcIn,
  input  logic [63:0] msgIn,
  input  logic        featEn,
  input  logic        mode64,
  output logic        rsvdExc,
  output logic        done,
  output logic        wrEn,
  output logic [63:0] result
);
  logic             bad;
  logic [CNT_W-1:0] nBytes;
  logic             castagSel;
  logic             noWrite;
  logic             busy;
  dpCtrl_t          dpCtrl;

  crc_accum_decode decode_i (
    .instr(instr), .featEn(featEn), .mode64(mode64), .bad(bad),
    .nBytes(nBytes), .castagSel(castagSel), .noWrite(noWrite)
  );

  crc_accum_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .bad(bad), .noWrite(noWrite),
    .nBytes(nBytes), .dpCtrl(dpCtrl), .busy(busy), .done(done), .wrEn(wrEn)
  );

  crc_accum_dp dp_i (
    .clk(clk), .rst_n(rst_n), .dpCtrl(dpCtrl), .crcIn(crcIn), .msgIn(msgIn),
    .nBytes(nBytes), .castagSel(castagSel), .result(result)
  );

  assign rsvdExc = start && !busy && bad;
endmodule

// File: rtl/crc_accum_sva.sv
module crc_accum_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        rsvdExc,
  input logic        done,
  input logic        wrEn,
  input logic [63:0] result
);
  AST_EXC_QUICK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsvdExc |=> (done && !wrEn)); // R5
  AST_EXC_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start |-> !rsvdExc); // R5
  AST_WRITE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> done); // R9
  AST_SIGN_EXTENDED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result[63:32] == {32{result[31]}})); // R8
  AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R10
endmodule

bind crc_accum_unit crc_accum_sva sva_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .rsvdExc(rsvdExc),
  .done(done), .wrEn(wrEn), .result(result)
);

// File: tb/crc_accum_unit_tb_top.sv
`timescale 1ns/1ps
module crc_accum_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] crcIn = '0;
  logic [63:0] msgIn = '0;
  logic        featEn = 1'b1;
  logic        mode64 = 1'b1;
  logic        rsvdExc, done, wrEn;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  crc_accum_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .crcIn(crcIn),
    .msgIn(msgIn), .featEn(featEn), .mode64(mode64), .rsvdExc(rsvdExc),
    .done(done), .wrEn(wrEn), .result(result)
  );

  function automatic logic [31:0] mkInstr(input logic [2:0] poly, input logic [1:0] sz,
                                          input logic [4:0] rt, input logic [4:0] rs);
    return {6'h1F, rs, rt, 5'd0, poly, sz, 6'h0F};
  endfunction

  function automatic logic [31:0] refCrc(input logic [31:0] c0, input logic [63:0] m,
                                         input int n, input bit castag);
    logic [31:0] c;
    logic [31:0] p;
    p = castag ? 32'h82F63B78 : 32'hEDB88320;
    c = c0;
    for (int i = 0; i < n; i++) begin
      c ^= {24'd0, m[i*8 +: 8]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ p) : (c >> 1);
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Issue one instruction and check exception, latency, write enable and result
  task automatic runOp(input logic [31:0] ins, input logic [63:0] c, input logic [63:0] m,
                       input bit fe, input bit m64, input bit expExc, input bit expWr,
                       input int expLat, input logic [31:0] expRes, input string req,
                       output logic [63:0] got);
    int k;
    @(negedge clk);
    instr = ins; crcIn = c; msgIn = m; featEn = fe; mode64 = m64; start = 1'b1;
    #1;
    check(rsvdExc == expExc, expExc ? "R5" : "R1", "rsvdExc in start cycle",
          64'(rsvdExc), 64'(expExc));
    @(negedge clk);
    start = 1'b0;
    k = 1;
    while (!done && k < 20) begin
      @(negedge clk);
      k++;
    end
    check(k == expLat, "R2", "done latency", 64'(k), 64'(expLat));
    check(wrEn == expWr, expExc ? "R5" : "R9", "wrEn on done", 64'(wrEn), 64'(expWr));
    got = result;
    if (!expExc) begin
      check(result[31:0] == expRes, req, "checksum", 64'(result[31:0]), 64'(expRes));
      check(result[63:32] == {32{expRes[31]}}, "R8", "sign extension",
            result, {{32{expRes[31]}}, expRes});
    end
    @(negedge clk);
    check(!done, "R2", "done is one cycle", 64'(done), 64'd0);
  endtask

  task automatic t_reset;
    check(!done && !wrEn && !rsvdExc, "R5", "reset outputs",
          {61'd0, done, wrEn, rsvdExc}, 64'd0);
  endtask

  task automatic t_sizes;
    logic [63:0] g;
    logic [63:0] m = 64'hF1E2D3C4B5A69788;
    logic [63:0] c = 64'hDEADBEEF_13579BDF;
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 2; p++) begin
        int n = 1 << s;
        logic [63:0] mm = (n == 8) ? m : (m & ((64'd1 << (8*n)) - 1));
        runOp(mkInstr(3'(p), 2'(s), 5'd3, 5'd4), c, m, 1'b1, 1'b1, 1'b0, 1'b1,
              n + 1, refCrc(c[31:0], mm, n, p[0]), p ? "R3" : "R7", g);
      end
    end
  endtask

  task automatic t_known;
    logic [63:0] g;
    logic [31:0] r;
    for (int p = 0; p < 2; p++) begin
      r = refCrc(32'hFFFFFFFF, 64'h3837363534333231, 8, p[0]);
      runOp(mkInstr(3'(p), 2'd3, 5'd1, 5'd2), 64'hFFFFFFFF, 64'h3837363534333231,
            1'b1, 1'b1, 1'b0, 1'b1, 9, r, "R6", g);
      r = refCrc(g[31:0], 64'h39, 1, p[0]);
      runOp(mkInstr(3'(p), 2'd0, 5'd1, 5'd2), g, 64'h39, 1'b1, 1'b1, 1'b0, 1'b1,
            2, r, "R6", g);
      check(~g[31:0] == (p ? 32'hE3069283 : 32'hCBF43926), "R3", "check value",
            64'(~g[31:0]), p ? 64'hE3069283 : 64'hCBF43926);
    end
  endtask

  task automatic t_mask;
    logic [63:0] g;
    // Upper bits of crcIn and of msgIn must not matter
    runOp(mkInstr(3'd0, 2'd1, 5'd5, 5'd6), 64'h5555AAAA_00000000, 64'hFFFFFFFF_FFFF1234,
          1'b1, 1'b1, 1'b0, 1'b1, 3, refCrc(32'h0, 64'h1234, 2, 1'b0), "R6", g);
    runOp(mkInstr(3'd1, 2'd2, 5'd5, 5'd6), 64'hFFFFFFFF_89ABCDEF, 64'hAAAAAAAA_01020304,
          1'b1, 1'b1, 1'b0, 1'b1, 5, refCrc(32'h89ABCDEF, 64'h01020304, 4, 1'b1), "R7", g);
  endtask

  task automatic t_exc;
    logic [63:0] g;
    logic [31:0] ok = mkInstr(3'd0, 2'd0, 5'd1, 5'd1);
    runOp(ok ^ 32'h8000_0000, 64'd1, 64'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1, 0, "R1", g);
    runOp(ok ^ 32'h0000_0001, 64'd1, 64'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1, 0, "R1", g);
    runOp(ok | 32'h0000_0800, 64'd1, 64'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1, 0, "R1", g);
    runOp(mkInstr(3'd2, 2'd0, 5'd1, 5'd1), 64'd1, 64'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1, 0, "R3", g);
    runOp(mkInstr(3'd7, 2'd1, 5'd1, 5'd1), 64'd1, 64'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1, 0, "R3", g);
    runOp(ok, 64'd1, 64'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1, 0, "R4", g);
    runOp(mkInstr(3'd1, 2'd3, 5'd1, 5'd1), 64'd1, 64'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1, 0, "R4", g);
    // Size below 3 without 64-bit mode stays legal
    runOp(mkInstr(3'd0, 2'd2, 5'd1, 5'd1), 64'h7, 64'h11223344, 1'b1, 1'b0, 1'b0, 1'b1,
          5, refCrc(32'h7, 64'h11223344, 4, 1'b0), "R4", g);
  endtask

  task automatic t_nop;
    logic [63:0] g;
    runOp(mkInstr(3'd0, 2'd2, 5'd0, 5'd9), 64'h1, 64'hCAFEF00D, 1'b1, 1'b1, 1'b0, 1'b0,
          5, refCrc(32'h1, 64'hCAFEF00D, 4, 1'b0), "R9", g);
  endtask

  task automatic t_busy;
    int k;
    int dones;
    logic [31:0] exp = refCrc(32'h2468ACE0, 64'h0BADF00D, 4, 1'b1);
    @(negedge clk);
    instr = mkInstr(3'd1, 2'd2, 5'd7, 5'd8); crcIn = 64'h2468ACE0; msgIn = 64'h0BADF00D;
    featEn = 1'b1; mode64 = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    instr = mkInstr(3'd0, 2'd3, 5'd7, 5'd8); crcIn = 64'h0; msgIn = 64'hFFFF; start = 1'b1;
    #1;
    check(!rsvdExc, "R10", "no exception while busy", 64'(rsvdExc), 64'd0);
    @(negedge clk);
    start = 1'b0;
    dones = 0;
    k = 3;
    while (!done && k < 20) begin
      @(negedge clk);
      k++;
    end
    check(k == 5, "R10", "original latency kept", 64'(k), 64'd5);
    check(result[31:0] == exp, "R10", "original result kept", 64'(result[31:0]), 64'(exp));
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done) dones++;
    end
    check(dones == 0, "R10", "no extra done", 64'(dones), 64'd0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_known();
    t_mask();
    t_exc();
    t_nop();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule